// File: doc/BRIEF.md
# Translation Buffer with Two-Level Page Walker

This block turns 32-bit virtual addresses into physical addresses for 1 KiB pages. An eight-entry, fully associative buffer compares the 22-bit page number of a request against every stored entry at once. On a hit the physical address comes back one cycle after the request is accepted, and no memory access is made. On a miss a hardware walker fetches a two-level table from memory. The top 12 bits of the virtual address index the first-level table and the next 10 bits index the second-level table. The walker then installs the result in the buffer and answers the request.

Software programs the base address of the first-level table through a write port and can empty the buffer in one cycle with a flush input. Only one walk runs at a time, and new requests are held off while it runs. The low 10 bits of the virtual address pass through unchanged. An invalid table entry at either level produces a page-fault response and leaves the buffer untouched. A write to a page without write permission is flagged on the response.

Top module: `xlat_unit`

## Requirements
- R1: Once reset is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_valid` is 0.
- R2: On a miss, the first table read goes to `base + vaddr[31:20]*4`. Its data is a first-level entry whose bits [31:10] give a second-level table at byte address `{pte[31:10],10'b0}`. The second read goes to that address plus `vaddr[19:10]*4`.
- R3: In a table entry, bit 0 is valid, bit 1 is writable and bits [31:10] hold the frame number. After a successful walk, `rsp_paddr = {frame, vaddr[9:0]}` and `rsp_fault` is 0.
- R4: A request whose page is held in the buffer is answered with `rsp_valid` in the cycle after acceptance, with the same physical address, and no memory read is made.
- R5: If the first-level entry has bit 0 clear, the response has `rsp_fault` = 1 after exactly one table read, and nothing is installed. A repeat of the request therefore walks again.
- R6: If the second-level entry has bit 0 clear, the response has `rsp_fault` = 1 after two table reads, and nothing is installed.
- R7: A request with `req_write` = 1 to a page whose entry has bit 1 clear gets `rsp_wprot` = 1. This holds both on a walk and on a buffer hit. A read to the same page gets `rsp_wprot` = 0.
- R8: A one-cycle `flush` pulse invalidates every buffer entry, so the next request to any page walks again.
- R9: Entries are replaced in round-robin order. After eight new pages are installed following the replacement of a given slot, the ninth new page evicts the oldest page, and the second-oldest page stays resident.
- R10: While a walk is in progress, `req_ready` is 0.
- R11: A write on `base_wr_en` sets the first-level table base used by every later walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Page fault: invalid table entry |
| rsp_wprot | output | 1 | Write to a page that is not writable |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rd_ack | input | 1 | Read data present |
| mem_rd_data | input | 32 | Table entry read from memory |
| base_wr_en | input | 1 | Write the table base register |
| base_wr_data | input | 32 | New table base address |
| flush | input | 1 | Invalidate all buffer entries |

## Verification
The hardest case to reach from the ports is eviction. It needs the replacement pointer to wrap around a full buffer, and the pointer's position is not visible at the ports. The stimulus flushes the buffer and installs nine pages that use distinct first-level indices. The oldest page is then expected to miss and the second-oldest to hit, and this order holds wherever the pointer started. Memory reads are counted per request, so a hit and a miss are told apart by how many table accesses each one made.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 10;
  localparam int L1_W   = 12;
  localparam int L2_W   = 10;
  localparam int VPN_W  = L1_W + L2_W;
  localparam int PPN_W  = VA_W - OFF_W;
  localparam int PTE_SH = 2;

  typedef struct packed {
    logic             ok;
    logic [PPN_W-1:0] ppn;
    logic             wr;
  } xlat_res_t;

  typedef enum logic [1:0] {W_IDLE, W_LVL1, W_LVL2} walk_st_t;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [PPN_W-1:0] look_ppn,
  output logic             look_wr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic               wr_q  [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0]   ptr_q, ptr_d;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign match[g] = vld_q[g] && (vpn_q[g] == look_vpn);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
        end else if (flush) begin
          vld_q[g] <= 1'b0;
        end else if (fill_en && (ptr_q == PTR_W'(g))) begin
          vld_q[g] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (fill_en && (ptr_q == PTR_W'(g))) begin
          vpn_q[g] <= fill_vpn;
          ppn_q[g] <= fill_ppn;
          wr_q[g]  <= fill_wr;
        end
      end
    end
  endgenerate

  always_comb begin
    look_hit = |match;
    look_ppn = '0;
    look_wr  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        look_ppn = look_ppn | ppn_q[i];
        look_wr  = look_wr | wr_q[i];
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (fill_en) begin
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R9
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VA_W-1:0]  start_va,
  input  logic             start_wr,
  input  logic [VA_W-1:0]  tbl_base,
  output logic             idle,
  output logic             mem_rd_valid,
  output logic [VA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_ack,
  input  logic [31:0]      mem_rd_data,
  output logic             done,
  output xlat_res_t        res,
  output logic [VA_W-1:0]  cur_va,
  output logic             cur_wr
);
  walk_st_t         st_q, st_d;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PPN_W-1:0] l2tbl_q;
  logic             cap_req, cap_l1;

  assign idle   = (st_q == W_IDLE);
  assign cur_va = va_q;
  assign cur_wr = wr_q;

  always_comb begin
    st_d         = st_q;
    cap_req      = 1'b0;
    cap_l1       = 1'b0;
    done         = 1'b0;
    res          = '0;
    mem_rd_valid = 1'b0;
    mem_rd_addr  = '0;
    unique case (st_q)
      W_IDLE: begin
        if (start) begin
          cap_req = 1'b1;
          st_d    = W_LVL1;
        end
      end
      W_LVL1: begin
        mem_rd_valid = 1'b1;
        mem_rd_addr  = tbl_base + (VA_W'(va_q[VA_W-1 -: L1_W]) << PTE_SH);
        if (mem_rd_ack) begin
          if (mem_rd_data[0]) begin
            cap_l1 = 1'b1;
            st_d   = W_LVL2;
          end else begin
            done = 1'b1;
            st_d = W_IDLE;
          end
        end
      end
      W_LVL2: begin
        mem_rd_valid = 1'b1;
        mem_rd_addr  = {l2tbl_q, {OFF_W{1'b0}}}
                     + (VA_W'(va_q[OFF_W +: L2_W]) << PTE_SH);
        if (mem_rd_ack) begin
          done   = 1'b1;
          res.ok = mem_rd_data[0];
          res.ppn = mem_rd_data[VA_W-1:OFF_W];
          res.wr = mem_rd_data[1];
          st_d   = W_IDLE;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_req) begin
      va_q <= start_va;
      wr_q <= start_wr;
    end
    if (cap_l1) begin
      l2tbl_q <= mem_rd_data[VA_W-1:OFF_W];
    end
  end

  // R2
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        rsp_wprot,
  output logic        mem_rd_valid,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [31:0] mem_rd_data,
  input  logic        base_wr_en,
  input  logic [31:0] base_wr_data,
  input  logic        flush
);
  logic [1:0]       rsync_q;
  logic             rs_n;
  logic [VA_W-1:0]  base_q;
  logic             accept, hit_acc, miss_acc;
  logic             look_hit, look_wr;
  logic [PPN_W-1:0] look_ppn;
  logic             walk_idle, walk_done;
  xlat_res_t        walk_res;
  logic [VA_W-1:0]  walk_va;
  logic             walk_wr;
  logic             fill_en;
  logic             rv_d, rf_d, rw_d;
  logic [VA_W-1:0]  ra_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rs_n = rsync_q[1];

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)           base_q <= '0;
    else if (base_wr_en) base_q <= base_wr_data;
  end

  assign req_ready = walk_idle;
  assign accept    = req_valid && req_ready;
  assign hit_acc   = accept && look_hit;
  assign miss_acc  = accept && !look_hit;
  assign fill_en   = walk_done && walk_res.ok;

  xlat_cam #(.ENTRIES(ENTRIES)) i_cam (
    .clk      (clk),
    .rst_n    (rs_n),
    .flush    (flush),
    .look_vpn (req_vaddr[VA_W-1:OFF_W]),
    .look_hit (look_hit),
    .look_ppn (look_ppn),
    .look_wr  (look_wr),
    .fill_en  (fill_en),
    .fill_vpn (walk_va[VA_W-1:OFF_W]),
    .fill_ppn (walk_res.ppn),
    .fill_wr  (walk_res.wr)
  );

  xlat_walker i_walk (
    .clk          (clk),
    .rst_n        (rs_n),
    .start        (miss_acc),
    .start_va     (req_vaddr),
    .start_wr     (req_write),
    .tbl_base     (base_q),
    .idle         (walk_idle),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ack   (mem_rd_ack),
    .mem_rd_data  (mem_rd_data),
    .done         (walk_done),
    .res          (walk_res),
    .cur_va       (walk_va),
    .cur_wr       (walk_wr)
  );

  always_comb begin
    rv_d = hit_acc || walk_done;
    rf_d = 1'b0;
    rw_d = 1'b0;
    ra_d = rsp_paddr;
    if (hit_acc) begin
      ra_d = {look_ppn, req_vaddr[OFF_W-1:0]};
      rw_d = req_write && !look_wr;
    end else if (walk_done) begin
      ra_d = walk_res.ok ? {walk_res.ppn, walk_va[OFF_W-1:0]} : '0;
      rf_d = !walk_res.ok;
      rw_d = walk_res.ok && walk_wr && !walk_res.wr;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_wprot <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= rv_d;
      rsp_fault <= rf_d;
      rsp_wprot <= rw_d;
      if (rv_d) rsp_paddr <= ra_d;
    end
  end

  // R10
  stall_walk_chk: assert property (@(posedge clk) disable iff (!rs_n)
    mem_rd_valid |-> !req_ready);

  // R4
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rs_n)
    hit_acc |=> (rsp_valid && !rsp_fault));

  // R5
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rs_n)
    rsp_fault |-> (rsp_valid && !rsp_wprot));
endmodule

// File: tb/test_xlat_unit.sv
module test_xlat_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, base_wr_en, flush;
  logic        req_ready, rsp_valid, rsp_fault, rsp_wprot;
  logic [31:0] req_vaddr, base_wr_data, rsp_paddr;
  logic        mem_rd_valid, mem_rd_ack;
  logic [31:0] mem_rd_addr, mem_rd_data;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] pt [logic [31:0]];
  int          nreads;
  logic [31:0] rd_log [4];
  logic [31:0] base_v;

  always #10 clk = ~clk;

  xlat_unit i_xlat_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_wprot(rsp_wprot),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .flush(flush)
  );

  // table memory: answers one cycle after a request
  always @(posedge clk) begin
    if (mem_rd_valid && !mem_rd_ack) begin
      mem_rd_ack  <= 1'b1;
      mem_rd_data <= pt.exists(mem_rd_addr) ? pt[mem_rd_addr] : 32'h0;
      if (nreads < 4) rd_log[nreads] <= mem_rd_addr;
      nreads      <= nreads + 1;
    end else begin
      mem_rd_ack  <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] l2_tbl(input logic [31:0] va);
    return 32'h0020_0000 + ({20'h0, va[31:20]} << 12);
  endfunction

  // build a mapping: l1ok/l2ok pick entry validity, wr sets bit 1
  task automatic map(input logic [31:0] va, input logic [21:0] frame,
                     input logic wr, input logic l1ok, input logic l2ok);
    pt[base_v + ({20'h0, va[31:20]} << 2)] = l2_tbl(va) | {31'h0, l1ok};
    pt[l2_tbl(va) + ({22'h0, va[19:10]} << 2)] = {frame, 8'h0, wr, l2ok};
  endtask

  task automatic xlat(input logic [31:0] va, input logic wr,
                      output logic [31:0] pa, output logic flt, output logic wp,
                      output int reads, output int lat, output logic stalled);
    int r0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    r0 = nreads;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; stalled = 1'b0;
    while (!rsp_valid && lat < 50) begin
      if (!req_ready) stalled = 1'b1;
      @(negedge clk);
      lat++;
    end
    pa = rsp_paddr; flt = rsp_fault; wp = rsp_wprot;
    reads = nreads - r0;
  endtask

  task automatic t_reset();
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
    base_v = b;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_walk_hit();
    logic [31:0] pa; logic f, w, s; int rd, lt;
    logic [31:0] va = 32'h1234_5678;
    map(va, 22'h2_ABCD, 1'b1, 1'b1, 1'b1);
    nreads = 0;
    xlat(va, 1'b0, pa, f, w, rd, lt, s);
    chk("R2 two reads", rd, 2);
    chk("R2 outer addr", rd_log[0], base_v + ({20'h0, va[31:20]} << 2));
    chk("R2 inner addr", rd_log[1], l2_tbl(va) + ({22'h0, va[19:10]} << 2));
    chk("R3 paddr", pa, {22'h2_ABCD, va[9:0]});
    chk("R3 no fault", {31'h0, f}, 32'h0);
    chk("R10 stalled during walk", {31'h0, s}, 32'h1);
    xlat(va ^ 32'h0000_0155, 1'b1, pa, f, w, rd, lt, s);
    chk("R4 hit no reads", rd, 0);
    chk("R4 hit latency", lt, 0);
    chk("R4 hit paddr", pa, {22'h2_ABCD, va[9:0] ^ 10'h155});
    chk("R7 writable no wprot", {31'h0, w}, 32'h0);
  endtask

  task automatic t_faults();
    logic [31:0] pa; logic f, w, s; int rd, lt;
    map(32'h4560_0000, 22'h111, 1'b1, 1'b0, 1'b1);
    xlat(32'h4560_0000, 1'b0, pa, f, w, rd, lt, s);
    chk("R5 outer fault", {31'h0, f}, 32'h1);
    chk("R5 one read", rd, 1);
    xlat(32'h4560_0000, 1'b0, pa, f, w, rd, lt, s);
    chk("R5 not installed", rd, 1);
    map(32'h7890_0C00, 22'h222, 1'b1, 1'b1, 1'b0);
    xlat(32'h7890_0C00, 1'b0, pa, f, w, rd, lt, s);
    chk("R6 inner fault", {31'h0, f}, 32'h1);
    chk("R6 two reads", rd, 2);
    xlat(32'h7890_0C00, 1'b0, pa, f, w, rd, lt, s);
    chk("R6 not installed", rd, 2);
  endtask

  task automatic t_wprot();
    logic [31:0] pa; logic f, w, s; int rd, lt;
    map(32'h0AB0_0400, 22'h333, 1'b0, 1'b1, 1'b1);
    xlat(32'h0AB0_0404, 1'b1, pa, f, w, rd, lt, s);
    chk("R7 walk wprot", {31'h0, w}, 32'h1);
    chk("R7 paddr", pa, {22'h333, 10'h004});
    xlat(32'h0AB0_0408, 1'b1, pa, f, w, rd, lt, s);
    chk("R7 hit wprot", {30'h0, w, rd[0]}, 32'h2);
    xlat(32'h0AB0_0408, 1'b0, pa, f, w, rd, lt, s);
    chk("R7 read ok", {31'h0, w}, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] pa; logic f, w, s; int rd, lt;
    do_flush();
    xlat(32'h1234_5678, 1'b0, pa, f, w, rd, lt, s);
    chk("R8 walk after flush", rd, 2);
  endtask

  task automatic t_rr();
    logic [31:0] pa; logic f, w, s; int rd, lt;
    do_flush();
    for (int i = 0; i < 9; i++) begin
      map(32'(i) << 20 | 32'h8000_0000, 22'(i + 16), 1'b1, 1'b1, 1'b1);
      xlat(32'(i) << 20 | 32'h8000_0000, 1'b0, pa, f, w, rd, lt, s);
    end
    xlat(32'h8010_0000, 1'b0, pa, f, w, rd, lt, s);
    chk("R9 second-oldest resident", rd, 0);
    xlat(32'h8080_0000, 1'b0, pa, f, w, rd, lt, s);
    chk("R9 newest resident", rd, 0);
    xlat(32'h8000_0000, 1'b0, pa, f, w, rd, lt, s);
    chk("R9 oldest evicted", rd, 2);
    chk("R9 refill paddr", pa, {22'd16, 10'h0});
  endtask

  task automatic t_base();
    logic [31:0] pa; logic f, w, s; int rd, lt;
    set_base(32'h0030_0000);
    map(32'h5550_0000, 22'h3F0F, 1'b1, 1'b1, 1'b1);
    nreads = 0;
    xlat(32'h5550_0000, 1'b0, pa, f, w, rd, lt, s);
    chk("R11 new base used", rd_log[0], 32'h0030_0000 + (32'h555 << 2));
    chk("R11 paddr", pa, {22'h3F0F, 10'h0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    base_wr_en = 1'b0; base_wr_data = '0; flush = 1'b0;
    mem_rd_ack = 1'b0; mem_rd_data = '0; nreads = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    set_base(32'h0010_0000);
    t_walk_hit();
    t_faults();
    t_wprot();
    t_flush();
    t_rr();
    t_base();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule